// File: doc/BRIEF.md
# Power-On Serial Register Default Loader

This block programs a small set of board devices with their default register values every time the board comes out of reset. When the delayed power-on or button reset goes high, the block steps through a built-in table of default entries. It sends each entry as one frame over a shared three-wire serial link: a serial clock, a serial data line and one active-low load line per target. There are three targets: a timing-generator chip, then a first and a second front-end converter. Each target has its own load line.

Each frame starts with a write bit that is always low, followed by the address field and then the data field. Both fields are sent least significant bit first. The timing generator takes a 4-bit address. The converters take a 3-bit address followed by a test bit that is always low. After the last frame the block raises a done flag. From then on it passes an external host's serial clock, data and load lines straight through, so that later register overrides can reach the devices.

Top module: `serial_default_loader`

## Requirements
- R1: While `rst_n` is low, all three `load_n` lines are high, `sclk` and `sdata` are low and `done` is low. Reset acts at once, without waiting for a clock edge.
- R2: After reset is released, frames go out in this order: every timing-generator entry (on `load_n[0]`), then every entry of converter 1 (on `load_n[1]`), then every entry of converter 2 (on `load_n[2]`). No other frames are sent.
- R3: During a frame, `sclk` has a period of `DIV` clock cycles: `DIV/2` cycles low, then `DIV/2` cycles high. `sdata` changes only while `sclk` is low, so it is stable across every rising edge. Outside frames, `sclk` is low until done.
- R4: A timing-generator frame has `5+TG_DW` bits, in this order: bit 0 is the write bit (0), bits 1..4 are the address LSB first, and then come `TG_DW` data bits LSB first.
- R5: A converter frame has `5+AFE_DW` bits, in this order: bit 0 is the write bit (0), bits 1..3 are the address LSB first, bit 4 is the test bit (0), and then come `AFE_DW` data bits LSB first.
- R6: At most one load line is low at any time. Each stays low for exactly the frame length times `DIV` cycles. Between two frames, all lines stay high for at least `DIV` cycles.
- R7: Entry i of target d (d = 0 for the timing generator, 1 and 2 for the converters) has address i. Its data is ((i+1)*37 + d*91) modulo 2^width of that target's data field.
- R8: After the last frame, `done` goes high and stays high until reset. While `done` is high, `sclk`, `sdata` and `load_n` follow `host_sclk`, `host_sdata` and `host_load_n`.
- R9: A reset that lands during a frame ends that frame at once. After the reset is released, the full sequence runs again from timing-generator entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Delayed power-on / button reset, active low, asynchronous |
| host_sclk | input | 1 | External host serial clock, passed through after done |
| host_sdata | input | 1 | External host serial data, passed through after done |
| host_load_n | input | 3 | External host load lines, passed through after done |
| sclk | output | 1 | Serial clock to the targets |
| sdata | output | 1 | Serial data to the targets |
| load_n | output | 3 | Active-low load lines: [0] timing generator, [1] converter 1, [2] converter 2 |
| done | output | 1 | Default loading finished; serial lines handed to the host |

## Verification
A reset press and an active frame can fall in the same cycle. This is the case in which a stale frame could leak or the sequence could resume part-way through. The bench provokes it by waiting until the third frame is on the wire and a few serial bits have gone out, then pulling reset low away from the clock edge. One time unit later it requires every load line high, the serial clock low and done low. After release, its frame monitor must see the whole table again, starting from timing-generator entry 0, with every frame bit-exact. The handover is also judged: the host lines must appear on the outputs only once done is high, and must keep following the host as its values change.

// File: rtl/serial_default_loader.sv
module serial_default_loader #(
  parameter int DIV    = 4,
  parameter int TG_N   = 4,
  parameter int TG_DW  = 8,
  parameter int AFE_N  = 3,
  parameter int AFE_DW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_sclk,
  input  logic       host_sdata,
  input  logic [2:0] host_load_n,
  output logic       sclk,
  output logic       sdata,
  output logic [2:0] load_n,
  output logic       done
);

  localparam int HALF   = DIV / 2;
  localparam int TG_FL  = 5 + TG_DW;
  localparam int AFE_FL = 5 + AFE_DW;
  localparam int FW     = (TG_FL > AFE_FL) ? TG_FL : AFE_FL;
  localparam int CW     = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int BW     = $clog2(FW + 1);
  localparam int NMAX   = (TG_N > AFE_N) ? TG_N : AFE_N;
  localparam int EW     = $clog2(NMAX + 1);

  typedef enum logic [1:0] {ST_START, ST_SHIFT, ST_GAP, ST_DONE} st_t;

  st_t           st;
  logic [CW-1:0] div_cnt;
  logic [BW-1:0] bit_cnt;
  logic [EW-1:0] ent;
  logic [1:0]    dev;
  logic [FW-1:0] shreg;

  function automatic logic [FW-1:0] frame_of(input logic [1:0] d, input logic [EW-1:0] i);
    logic [31:0]   v;
    logic [3:0]    a;
    logic [FW-1:0] f;
    v = (32'(i) + 32'd1) * 32'd37 + 32'(d) * 32'd91;
    a = 4'(i);
    f = '0;
    if (d == 2'd0) begin
      f[4:1] = a;
      for (int b = 0; b < TG_DW; b++) f[5+b] = v[b];
    end else begin
      f[3:1] = a[2:0];
      for (int b = 0; b < AFE_DW; b++) f[5+b] = v[b];
    end
    return f;
  endfunction

  logic [BW-1:0] flen_m1;
  logic [EW-1:0] last_ent;
  logic          period_end;

  assign flen_m1    = (dev == 2'd0) ? BW'(TG_FL - 1) : BW'(AFE_FL - 1);
  assign last_ent   = (dev == 2'd0) ? EW'(TG_N - 1) : EW'(AFE_N - 1);
  assign period_end = (div_cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_START;
      div_cnt <= '0;
      bit_cnt <= '0;
      ent     <= '0;
      dev     <= 2'd0;
      shreg   <= '0;
    end else begin
      case (st)
        ST_START: begin
          st      <= ST_SHIFT;
          dev     <= 2'd0;
          ent     <= '0;
          div_cnt <= '0;
          bit_cnt <= '0;
          shreg   <= frame_of(2'd0, '0);
        end
        ST_SHIFT: begin
          div_cnt <= period_end ? '0 : div_cnt + 1'b1;
          if (period_end) begin
            if (bit_cnt == flen_m1) begin
              st      <= ST_GAP;
              bit_cnt <= '0;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
              shreg   <= shreg >> 1;
            end
          end
        end
        ST_GAP: begin
          div_cnt <= period_end ? '0 : div_cnt + 1'b1;
          if (period_end) begin
            if (ent == last_ent) begin
              if (dev == 2'd2) begin
                st <= ST_DONE;
              end else begin
                st    <= ST_SHIFT;
                dev   <= dev + 2'd1;
                ent   <= '0;
                shreg <= frame_of(dev + 2'd1, '0);
              end
            end else begin
              st    <= ST_SHIFT;
              ent   <= ent + 1'b1;
              shreg <= frame_of(dev, ent + 1'b1);
            end
          end
        end
        default: st <= ST_DONE;
      endcase
    end
  end

  logic       int_sclk;
  logic       int_sdata;
  logic [2:0] int_load_n;

  assign int_sclk   = (st == ST_SHIFT) && (div_cnt >= CW'(HALF));
  assign int_sdata  = (st == ST_SHIFT) && shreg[0];
  assign int_load_n = (st == ST_SHIFT) ? ~(3'b001 << dev) : 3'b111;
  assign done       = (st == ST_DONE);

  assign sclk   = done ? host_sclk   : int_sclk;
  assign sdata  = done ? host_sdata  : int_sdata;
  assign load_n = done ? host_load_n : int_load_n;

  // R6
  one_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $onehot0(~load_n));

  // R3
  idle_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && (&load_n)) |-> !sclk);

  // R3
  data_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && $rose(sclk)) |-> $stable(sdata));

  // R6
  load_fall_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !(&load_n) && $past(&load_n)) |-> !sclk);

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R4
  bit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SHIFT) |-> (bit_cnt <= flen_m1));

endmodule

// File: tb/serial_default_loader_test.sv
module serial_default_loader_test;

  localparam int DIV    = 4;
  localparam int TG_N   = 4;
  localparam int TG_DW  = 8;
  localparam int AFE_N  = 3;
  localparam int AFE_DW = 8;
  localparam int TOTAL  = TG_N + 2 * AFE_N;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_sclk, host_sdata;
  logic [2:0] host_load_n;
  logic       sclk, sdata, done;
  logic [2:0] load_n;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  serial_default_loader #(.DIV(DIV), .TG_N(TG_N), .TG_DW(TG_DW),
                          .AFE_N(AFE_N), .AFE_DW(AFE_DW)) uut (
    .clk(clk), .rst_n(rst_n), .host_sclk(host_sclk), .host_sdata(host_sdata),
    .host_load_n(host_load_n), .sclk(sclk), .sdata(sdata), .load_n(load_n),
    .done(done));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int dev_of(input int n);
    if (n < TG_N) return 0;
    if (n < TG_N + AFE_N) return 1;
    return 2;
  endfunction

  function automatic int idx_of(input int n);
    if (n < TG_N) return n;
    if (n < TG_N + AFE_N) return n - TG_N;
    return n - TG_N - AFE_N;
  endfunction

  function automatic int len_of(input int d);
    return (d == 0) ? 5 + TG_DW : 5 + AFE_DW;
  endfunction

  function automatic logic [31:0] exp_frame(input int d, input int i);
    logic [31:0] val, fr;
    int dw;
    val = 32'((i + 1) * 37 + d * 91);
    dw  = (d == 0) ? TG_DW : AFE_DW;
    fr  = 32'd0;
    for (int b = 0; b < 4; b++)
      if (d == 0 || b < 3) fr[1+b] = (i >> b) & 1;
    for (int b = 0; b < dw; b++) fr[5+b] = val[b];
    return fr;
  endfunction

  int          nframes;
  int          nbits, lowcnt, gapcnt, risecnt, fdev;
  logic [31:0] got;
  logic        prev_sclk, prev_sdata;
  logic [2:0]  prev_low;

  always @(negedge clk) begin
    if (!rst_n) begin
      nframes = 0; nbits = 0; lowcnt = 0; gapcnt = 0; risecnt = 0; fdev = 0;
      got = 0; prev_sclk = 0; prev_sdata = 0; prev_low = 0;
    end else if (!done) begin
      if (load_n != 3'b111) begin
        if (prev_low == 3'b000) begin
          fdev = dev_of(nframes);
          chk(nframes < TOTAL, "R2 extra frame", nframes, TOTAL);
          chk(load_n == ~(3'b001 << fdev), "R2 load line", load_n, ~(3'b001 << fdev));
          if (nframes > 0) chk(gapcnt >= DIV, "R6 gap", gapcnt, DIV);
          nbits = 0; lowcnt = 0; got = 0; risecnt = 0;
        end
        lowcnt++;
        if (sclk && !prev_sclk) begin
          chk(sdata == prev_sdata, "R3 data stable at rise", sdata, prev_sdata);
          if (nbits > 0) chk(risecnt == DIV, "R3 period", risecnt, DIV);
          risecnt = 1;
          if (nbits < 32) got[nbits] = sdata;
          nbits++;
        end else begin
          risecnt++;
        end
      end else begin
        if (prev_low != 3'b000) begin
          chk(lowcnt == len_of(fdev) * DIV, "R6 load low length", lowcnt, len_of(fdev) * DIV);
          chk(nbits == len_of(fdev), "R4 R5 frame bits", nbits, len_of(fdev));
          if (fdev == 0)
            chk(got == exp_frame(0, idx_of(nframes)), "R4 R7 generator frame", got, exp_frame(0, idx_of(nframes)));
          else
            chk(got == exp_frame(fdev, idx_of(nframes)), "R5 R7 converter frame", got, exp_frame(fdev, idx_of(nframes)));
          nframes++;
          gapcnt = 0;
        end
        gapcnt++;
        if (sclk) chk(0, "R3 sclk idle", sclk, 0);
      end
      prev_sclk = sclk; prev_sdata = sdata; prev_low = ~load_n;
    end
  end

  task automatic wait_done();
    int n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(done, "R8 done reached", done, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    host_sclk = 1'b1; host_sdata = 1'b1; host_load_n = 3'b101;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(load_n == 3'b111, "R1 load lines", load_n, 3'b111);
    chk(!sclk && !sdata, "R1 sclk sdata", {sclk, sdata}, 0);
    chk(!done, "R1 done", done, 0);

    rst_n = 1'b1;
    wait_done();
    chk(nframes == TOTAL, "R2 frame count", nframes, TOTAL);
    #1;
    chk({sclk, sdata, load_n} == 5'b11101, "R8 host passthrough", {sclk, sdata, load_n}, 5'b11101);
    @(negedge clk);
    host_sclk = 1'b0; host_sdata = 1'b0; host_load_n = 3'b110;
    #1;
    chk({sclk, sdata, load_n} == 5'b00110, "R8 host follow", {sclk, sdata, load_n}, 5'b00110);
    repeat (7) @(negedge clk);
    chk(done, "R8 done held", done, 1);

    rst_n = 1'b0;
    #1;
    chk(!done && load_n == 3'b111, "R1 reset after done", {done, load_n}, 4'b0111);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    wait (nframes == 2 && load_n != 3'b111);
    repeat (10) @(negedge clk);
    #2;
    chk(load_n == 3'b110, "R9 frame in progress", load_n, 3'b110);
    rst_n = 1'b0;
    #1;
    chk(load_n == 3'b111, "R9 abort load", load_n, 3'b111);
    chk(!sclk && !done, "R9 abort sclk done", {sclk, done}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_done();
    chk(nframes == TOTAL, "R9 full rerun", nframes, TOTAL);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule